// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps time of day and calendar date in packed BCD, from seconds up to a two-digit year. Time advances on a 32.768 kHz enable input that a prescaler divides down to a one-second update. The same prescaler also yields a 32 Hz tick. Two flags in the control register sit between the running counters and the host-visible time registers. Raising the snapshot flag copies the counters into holding registers, which then stay still while time moves on. Setting the freeze flag stops the counters. Clearing it again loads whatever the host has written into the counters and restarts the second.

A calibration mode drives a nominal 512 Hz square wave onto a dedicated output and withholds the interrupt permit. In this mode the host may program a signed correction. The correction then lengthens or shortens one second in every calibration window by a number of prescaler pulses. A century flag reports the year wrapping from 99 to 00 and clears when the control register is read. An oscillator-off bit halts timekeeping.

Register map on the 4-bit address: 0 control, 1 calibration, 2 seconds, 3 minutes, 4 hours, 5 day of week, 6 date, 7 month, 8 year. Other addresses read as zero. Writes take effect at the clock edge. Read data is combinational from the address, and the read-clear happens at the edge where `regRe` is high.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset the control and calibration registers read 00h, and the time registers read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00.
- R2: With the enable high and no correction pending, `secTick` pulses once every 2^DIV_W enabled ticks. `tick32` pulses 32 times in each such second, and one of those pulses falls in the same cycle as `secTick`.
- R3: On each second update, the seconds and minutes count 00–59 in BCD, the hours count 00–23, and the day of week steps 1..7 and back to 1 at midnight.
- R4: At midnight the date advances to 01 of the next month after the month's last day. A month ends on day 30 for months 04, 06, 09 and 11, and on day 31 for the other months except 02. Month 02 ends on day 29 when the binary year value is divisible by 4, else on day 28. The month wraps from 12 to 01 and the year from 99 to 00.
- R5: Writing control bit 0 from 0 to 1 copies the seven counters into the holding registers read at addresses 2..8. The holding registers do not change while the counters advance, and no new copy is made until bit 0 has been written 0 and then 1 again.
- R6: If the copy would fall on the edge of a second update, it is taken one cycle later, so it always shows the updated time.
- R7: While control bit 1 is 1 the counters do not advance. Writing bit 1 from 1 to 0 loads the seven time registers into the counters and restarts the second, so the next `secTick` comes 2^DIV_W enabled ticks after that edge.
- R8: Control bit 7 (read-only) is set when the year wraps from 99 to 00 and is cleared by a read of address 0.
- R9: While control bit 2 (calibration mode) is 1, `calWave` is a square wave with a period of 2^(DIV_W−9) enabled ticks and `irqPermit` is 0. Otherwise `calWave` is 0 and `irqPermit` is 1.
- R10: The calibration register holds a sign in bit 4 and a magnitude in bits 3..0. Writes to it are ignored unless calibration mode was already 1.
- R11: Every 2^CAL_WIN_W seconds, one second is lengthened by the magnitude in enabled ticks when the sign is 1, or shortened by it when the sign is 0.
- R12: While control bit 3 is 1 there are no `secTick` or `tick32` pulses and the counters hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | 32.768 kHz timebase enable |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (clears century flag on address 0) |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` |
| secTick | output | 1 | One-second pulse |
| tick32 | output | 1 | 32 Hz pulse |
| calWave | output | 1 | 512 Hz square wave in calibration mode |
| irqPermit | output | 1 | Low while interrupts are suppressed by calibration mode |

## Verification
The two functions that can meet in one cycle are the snapshot request and the one-second counter update. The bench loads a known time, which restarts the second from a known phase. It then raises the snapshot bit three, two and one cycles ahead of the update edge. The earliest case must return the old time. The other two must return the advanced time, which shows that a copy due on the update edge was deferred rather than taken from the pre-update counters.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

  localparam int TIME_REGS = 7;

  localparam logic [3:0] ADDR_CTRL  = 4'd0;
  localparam logic [3:0] ADDR_CAL   = 4'd1;
  localparam logic [3:0] ADDR_TIME0 = 4'd2;

  // control datapath strobes
  typedef struct packed {
    logic advance;   // step the counters by one second
    logic load;      // counters <= host registers
    logic capture;   // host registers <= counters
  } strobeT;

  // reset value of a time field: day of week, date and month start at 1
  function automatic logic [7:0] fieldReset(input int idx);
    return (idx >= 3 && idx <= 5) ? 8'h01 : 8'h00;
  endfunction

endpackage

// File: rtl/rtc_bcd_ctrl.sv
module rtc_bcd_ctrl
  import rtc_bcd_pkg::*;
#(
  parameter int DIV_W     = 15,
  parameter int CAL_WIN_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [3:0] regAddr,
  input  logic [4:0] ctrlWdata,
  input  logic       yearWrap,
  output strobeT     strobe,
  output logic [3:0] ctrlBits,
  output logic [4:0] calSetting,
  output logic       centuryFlag,
  output logic       secTick,
  output logic       tick32,
  output logic       calWave
);

  localparam int RAW_W  = DIV_W - 9;  // uncorrected 512 Hz tap
  localparam int FAST_W = DIV_W - 5;  // 32 Hz boundary

  logic rBit, wBit, calMode, oscOff;
  logic calSign;
  logic [3:0] calMag;
  logic [3:0] pend;
  logic pendSign;
  logic [DIV_W-1:0] div;
  logic [RAW_W-1:0] rawCnt;
  logic [CAL_WIN_W-1:0] winCnt;
  logic snapPend;

  logic effTick;
  logic [1:0] step;
  logic [DIV_W:0] sum;
  logic ctrlWr, calWr, rRise, wFall;

  always_comb begin
    ctrlWr  = regWe && (regAddr == ADDR_CTRL);
    calWr   = regWe && (regAddr == ADDR_CAL) && calMode;
    rRise   = ctrlWr && ctrlWdata[0] && !rBit;
    wFall   = ctrlWr && !ctrlWdata[1] && wBit;
    effTick = tickEn && !oscOff;
    if (pend == '0)     step = 2'd1;
    else if (pendSign)  step = 2'd0;   // swallow a pulse
    else                step = 2'd2;   // insert a pulse
    sum     = {1'b0, div} + (DIV_W+1)'(step);
    secTick = effTick && sum[DIV_W];
    tick32  = effTick && (sum[DIV_W:FAST_W] != {1'b0, div[DIV_W-1:FAST_W]});
    strobe.load    = wFall;
    strobe.advance = secTick && !wBit;
    strobe.capture = snapPend && !strobe.advance;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {oscOff, calMode, wBit, rBit} <= '0;
      {calSign, calMag} <= '0;
      pend        <= '0;
      pendSign    <= 1'b0;
      div         <= '0;
      rawCnt      <= '0;
      winCnt      <= '0;
      snapPend    <= 1'b0;
      centuryFlag <= 1'b0;
    end else begin
      if (ctrlWr) {oscOff, calMode, wBit, rBit} <= ctrlWdata[3:0];
      if (calWr)  {calSign, calMag} <= ctrlWdata;

      if (rRise)               snapPend <= 1'b1;
      else if (strobe.capture) snapPend <= 1'b0;

      if (effTick) rawCnt <= rawCnt + 1'b1;

      if (wFall)        div <= '0;
      else if (effTick) div <= sum[DIV_W-1:0];

      if (effTick && pend != '0) pend <= pend - 1'b1;
      if (secTick) begin
        winCnt <= winCnt + 1'b1;
        if (&winCnt) begin
          pend     <= calMag;
          pendSign <= calSign;
        end
      end

      if (strobe.advance && yearWrap)                 centuryFlag <= 1'b1;
      else if (regRe && regAddr == ADDR_CTRL)         centuryFlag <= 1'b0;
    end
  end

  assign ctrlBits   = {oscOff, calMode, wBit, rBit};
  assign calSetting = {calSign, calMag};
  assign calWave    = calMode && rawCnt[RAW_W-1];

endmodule

// File: rtl/rtc_bcd_dp.sv
module rtc_bcd_dp
  import rtc_bcd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobeT                        strobe,
  input  logic                          regWe,
  input  logic [3:0]                    regAddr,
  input  logic [7:0]                    regWdata,
  output logic [TIME_REGS-1:0][7:0]     hostReg,
  output logic [TIME_REGS-1:0][7:0]     liveTime,
  output logic                          yearWrap
);

  // field order: 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year
  logic [TIME_REGS-1:0][7:0] cnt, nxt;
  logic secWrap, minWrap, hourWrap, dateWrap, monWrap, leap;
  logic [1:0] leapSum;
  logic [7:0] lastDay;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  always_comb begin
    // (10*tens + units) mod 4 == (2*tens + units) mod 4
    leapSum = {cnt[6][4], 1'b0} + cnt[6][1:0];
    leap    = (leapSum == 2'd0);
    case (cnt[5])
      8'h02:                      lastDay = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDay = 8'h30;
      default:                    lastDay = 8'h31;
    endcase
    secWrap  = (cnt[0] == 8'h59);
    minWrap  = secWrap  && (cnt[1] == 8'h59);
    hourWrap = minWrap  && (cnt[2] == 8'h23);
    dateWrap = hourWrap && (cnt[4] == lastDay);
    monWrap  = dateWrap && (cnt[5] == 8'h12);
    yearWrap = monWrap  && (cnt[6] == 8'h99);

    nxt    = cnt;
    nxt[0] = secWrap ? 8'h00 : bcdInc(cnt[0]);
    if (secWrap) nxt[1] = minWrap ? 8'h00 : bcdInc(cnt[1]);
    if (minWrap) nxt[2] = hourWrap ? 8'h00 : bcdInc(cnt[2]);
    if (hourWrap) begin
      nxt[3] = (cnt[3] == 8'h07) ? 8'h01 : cnt[3] + 8'd1;
      nxt[4] = dateWrap ? 8'h01 : bcdInc(cnt[4]);
    end
    if (dateWrap) nxt[5] = monWrap ? 8'h01 : bcdInc(cnt[5]);
    if (monWrap)  nxt[6] = yearWrap ? 8'h00 : bcdInc(cnt[6]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TIME_REGS; i++) cnt[i] <= fieldReset(i);
    end else if (strobe.load) begin
      cnt <= hostReg;
    end else if (strobe.advance) begin
      cnt <= nxt;
    end
  end

  for (genvar gi = 0; gi < TIME_REGS; gi++) begin : g_field
    logic [7:0] fld;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               fld <= fieldReset(gi);
      else if (strobe.capture) fld <= cnt[gi];
      else if (regWe && regAddr == 4'(ADDR_TIME0 + gi)) fld <= regWdata;
    end
    assign hostReg[gi] = fld;
  end

  assign liveTime = cnt;

endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_bcd_pkg::*;
#(
  parameter int DIV_W     = 15,
  parameter int CAL_WIN_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [3:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       secTick,
  output logic       tick32,
  output logic       calWave,
  output logic       irqPermit
);

  strobeT strobe;
  logic [3:0] ctrlBits;
  logic [4:0] calSetting;
  logic centuryFlag, yearWrap;
  logic [TIME_REGS-1:0][7:0] hostReg, liveTime;

  rtc_bcd_ctrl #(.DIV_W(DIV_W), .CAL_WIN_W(CAL_WIN_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .ctrlWdata(regWdata[4:0]), .yearWrap(yearWrap),
    .strobe(strobe), .ctrlBits(ctrlBits), .calSetting(calSetting),
    .centuryFlag(centuryFlag), .secTick(secTick), .tick32(tick32), .calWave(calWave)
  );

  rtc_bcd_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .hostReg(hostReg), .liveTime(liveTime), .yearWrap(yearWrap)
  );

  always_comb begin
    regRdata = 8'h00;
    if (regAddr == ADDR_CTRL)     regRdata = {centuryFlag, 3'b000, ctrlBits};
    else if (regAddr == ADDR_CAL) regRdata = {3'b000, calSetting};
    else begin
      for (int i = 0; i < TIME_REGS; i++)
        if (regAddr == 4'(ADDR_TIME0 + i)) regRdata = hostReg[i];
    end
  end

  assign irqPermit = !ctrlBits[2];

endmodule

// File: rtl/rtc_bcd_clock_chk.sv
module rtc_bcd_clock_chk
  import rtc_bcd_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      regWe,
  input logic                      regRe,
  input logic [3:0]                regAddr,
  input logic                      secTick,
  input logic                      tick32,
  input logic [3:0]                ctrlBits,
  input logic [4:0]                calSetting,
  input logic                      centuryFlag,
  input strobeT                    strobe,
  input logic [TIME_REGS-1:0][7:0] hostReg,
  input logic [TIME_REGS-1:0][7:0] liveTime
);

  // R2
  sec_has_fast_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> tick32);

  // R12
  osc_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBits[3] |-> (!secTick && !tick32));

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[1] && !strobe.load) |=> $stable(liveTime));

  // R5
  snapshot_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && !(regWe && regAddr >= 4'd2 && regAddr <= 4'd8)) |=> $stable(hostReg));

  // R6
  snapshot_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.load) |=> (hostReg == liveTime));

  // R8
  century_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == 4'd0 && !strobe.advance) |=> !centuryFlag);

  // R10
  cal_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBits[2] |=> $stable(calSetting));

endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk i_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
  .secTick(secTick), .tick32(tick32), .ctrlBits(ctrlBits), .calSetting(calSetting),
  .centuryFlag(centuryFlag), .strobe(strobe), .hostReg(hostReg), .liveTime(liveTime)
);

// File: tb/test_rtc_bcd_clock.sv
`timescale 1ns/1ps
module test_rtc_bcd_clock;
  localparam int DIV_W = 11;
  localparam int CAL_WIN_W = 2;
  localparam int SEC = 1 << DIV_W;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, regWe = 1'b0, regRe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic secTick, tick32, calWave, irqPermit;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_bcd_clock #(.DIV_W(DIV_W), .CAL_WIN_W(CAL_WIN_W)) i_rtc_bcd_clock (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .secTick(secTick), .tick32(tick32), .calWave(calWave), .irqPermit(irqPermit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int daysIn(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    regAddr = a; regRe = 1'b1; #1 d = regRdata;
    @(negedge clk); regRe = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitSec(output int n);
    n = 0;
    while (!secTick) begin @(negedge clk); n++; end
  endtask

  task automatic interval(output int n, output int f);
    n = 0; f = 0;
    do begin @(negedge clk); n++; if (tick32) f++; end while (!secTick);
  endtask

  task automatic setTime(input logic [7:0] t [7]);
    wr(4'd0, 8'h02);
    for (int i = 0; i < 7; i++) wr(4'(2 + i), t[i]);
    wr(4'd0, 8'h00);
  endtask

  task automatic snap(input logic [7:0] base, output logic [7:0] t [7]);
    wr(4'd0, base | 8'h01);
    cycles(2);
    for (int i = 0; i < 7; i++) rd(4'(2 + i), t[i]);
    wr(4'd0, base);
  endtask

  task automatic rollTest(input string req, input logic [7:0] st [7], input logic [7:0] ex [7]);
    logic [7:0] got [7];
    int n;
    setTime(st);
    waitSec(n);
    cycles(1);
    snap(8'h00, got);
    for (int i = 0; i < 7; i++) chk(req, got[i], ex[i]);
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] d;
    logic [7:0] t1 [7];
    logic [7:0] t2 [7];
    logic [7:0] st [7];
    logic [7:0] ex [7];
    int n, f, sumN, nominal, hi, cnt;

    repeat (4) @(negedge clk);
    rstN = 1'b1; tickEn = 1'b1;

    // R1 reset state
    rd(4'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(4'd1, d); chk("R1 cal", d, 8'h00);
    ex = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    for (int i = 0; i < 7; i++) begin rd(4'(2 + i), d); chk("R1 time", d, ex[i]); end

    // R2 divider period and 32 Hz taps
    waitSec(n);
    for (int k = 0; k < 2; k++) begin
      interval(n, f);
      chk("R2 second period", n, SEC);
      chk("R2 fast ticks per second", f, 32);
    end

    // R7 load restart: first tick 2^DIV_W ticks after the load edge
    st = '{8'h08, 8'h34, 8'h12, 8'h02, 8'h15, 8'h06, 8'h24};
    setTime(st);
    waitSec(n);
    chk("R7 restart phase", n + 1, SEC);
    cycles(1);

    // R5 snapshot stability and re-arm
    setTime(st);
    wr(4'd0, 8'h01); cycles(2);
    rd(4'd2, d); chk("R5 first copy", d, 8'h08);
    waitSec(n); cycles(3);
    rd(4'd2, d); chk("R5 stable while counting", d, 8'h08);
    wr(4'd0, 8'h01); cycles(2);
    rd(4'd2, d); chk("R5 no copy without re-arm", d, 8'h08);
    wr(4'd0, 8'h00); wr(4'd0, 8'h01); cycles(2);
    rd(4'd2, d); chk("R5 copy after re-arm", d, 8'h09);
    wr(4'd0, 8'h00);

    // R6 snapshot against the update edge
    for (int k = 3; k >= 1; k--) begin
      setTime(st);
      cycles(SEC - k);
      wr(4'd0, 8'h01); cycles(2);
      rd(4'd2, d);
      chk("R6 copy near update", d, (k == 3) ? 8'h08 : 8'h09);
      wr(4'd0, 8'h00);
    end

    // R7 freeze holds counters
    wr(4'd0, 8'h02);
    snap(8'h02, t1);
    cycles(SEC + 500);
    snap(8'h02, t2);
    for (int i = 0; i < 7; i++) chk("R7 frozen", t2[i], t1[i]);
    wr(4'd0, 8'h00);

    // R3 BCD digit, minute and hour carries
    st = '{8'h59, 8'h59, 8'h09, 8'h05, 8'h10, 8'h03, 8'h24};
    ex = '{8'h00, 8'h00, 8'h10, 8'h05, 8'h10, 8'h03, 8'h24};
    rollTest("R3 hour carry", st, ex);
    st = '{8'h59, 8'h09, 8'h19, 8'h05, 8'h10, 8'h03, 8'h24};
    ex = '{8'h00, 8'h10, 8'h19, 8'h05, 8'h10, 8'h03, 8'h24};
    rollTest("R3 minute digit", st, ex);

    // R4 month-end sweep over a leap and a common year
    for (int yi = 0; yi < 2; yi++) begin
      int y;
      y = (yi == 0) ? 24 : 25;
      for (int m = 1; m <= 12; m++) begin
        st = '{8'h59, 8'h59, 8'h23, 8'h03, bcd(daysIn(m, y)), bcd(m), bcd(y)};
        ex = '{8'h00, 8'h00, 8'h00, 8'h04, 8'h01, bcd(m % 12 + 1),
               bcd((m == 12) ? (y + 1) % 100 : y)};
        rollTest("R4 month end", st, ex);
      end
    end
    // R4 leap day reached in a leap year, including year 00
    st = '{8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00};
    ex = '{8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h00};
    rollTest("R4 leap day 00", st, ex);
    st[6] = 8'h96; ex[6] = 8'h96;
    rollTest("R4 leap day 96", st, ex);

    // R8 century wrap with R3 day-of-week wrap
    rd(4'd0, d); chk("R8 flag clear before", d, 8'h00);
    st = '{8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};
    ex = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    rollTest("R8 R3 century and weekday wrap", st, ex);
    rd(4'd0, d); chk("R8 flag set", d, 8'h80);
    rd(4'd0, d); chk("R8 flag cleared by read", d, 8'h00);

    // R9 calibration square wave and interrupt suppression
    wr(4'd0, 8'h04);
    hi = 0;
    for (int k = 0; k < 16; k++) begin @(negedge clk); if (calWave) hi++; end
    chk("R9 wave duty in cal mode", hi, 8);
    chk("R9 irq suppressed", irqPermit, 1'b0);

    // R10 cal write accepted in cal mode
    wr(4'd1, 8'h15);
    rd(4'd1, d); chk("R10 cal written", d, 8'h15);
    wr(4'd0, 8'h00);
    hi = 0;
    for (int k = 0; k < 16; k++) begin @(negedge clk); if (calWave) hi++; end
    chk("R9 no wave outside cal mode", hi, 0);
    chk("R9 irq permitted", irqPermit, 1'b1);
    wr(4'd1, 8'h07);
    rd(4'd1, d); chk("R10 cal write ignored", d, 8'h15);

    // R11 remove 5 pulses per window
    waitSec(n);
    sumN = 0; nominal = 0;
    for (int k = 0; k < 4; k++) begin
      interval(n, f); sumN += n; if (n == SEC) nominal++;
    end
    chk("R11 window length slow", sumN, 4 * SEC + 5);
    chk("R11 single corrected second slow", nominal, 3);

    // R11 add 3 pulses per window
    wr(4'd0, 8'h04); wr(4'd1, 8'h03); wr(4'd0, 8'h00);
    waitSec(n);
    sumN = 0; nominal = 0;
    for (int k = 0; k < 4; k++) begin
      interval(n, f); sumN += n; if (n == SEC) nominal++;
    end
    chk("R11 window length fast", sumN, 4 * SEC - 3);
    chk("R11 single corrected second fast", nominal, 3);
    wr(4'd0, 8'h04); wr(4'd1, 8'h00); wr(4'd0, 8'h00);

    // R12 oscillator off
    wr(4'd0, 8'h08);
    snap(8'h08, t1);
    cnt = 0;
    for (int k = 0; k < SEC + 500; k++) begin
      @(negedge clk); if (secTick || tick32) cnt++;
    end
    chk("R12 no ticks", cnt, 0);
    snap(8'h08, t2);
    for (int i = 0; i < 7; i++) chk("R12 counters held", t2[i], t1[i]);
    wr(4'd0, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule